// File: doc/BRIEF.md
# Byte-wide ATM cell port toward a PHY

This block carries 53-byte ATM cells between the cell buffers of an ATM-layer device and a PHY device over an 8-bit bus, with one path in each direction. Both paths run on `clk_i`. The integration also sends that clock to the PHY as its receive and transmit clock. On the receive path, the block decides each cycle whether to enable the PHY. It then captures the byte the PHY presents, tracks the byte position within the cell, and delivers a byte stream to the internal buffer. That stream carries a start marker, an end marker and a framing-error pulse. On the transmit path, the block takes bytes from an internal stream marked with a start-of-cell flag. It launches those bytes toward the PHY with a transmit enable and a start-of-cell strobe.

A static mode input selects the flow-control scheme. With octet handshake, each path's status input is a per-byte flag. On receive it is high when the current byte is valid. On transmit it is high while the PHY has room. With cell handshake, the same inputs mean that a whole cell is available. They are consulted only at cell boundaries, and once a cell has started it runs without them. The transmitter sends nothing, not even idle cells, unless the internal side reports an active transmit channel.

Top module: `utopia_port`

## Requirements
- R1: While `rst_ni` is low, `rx_enb_no` and `tx_enb_no` are high, and `rx_valid_o`, `rx_frm_err_o` and `tx_soc_o` are low.
- R2: A receive byte is captured at a rising edge where `rx_enb_no` is low and the byte is valid. In octet mode, valid means `rx_stat_i` is high. In cell mode, every enabled cycle is valid. The captured byte appears on `rx_byte_o` with `rx_valid_o` high in the cycle after that edge. No capture means `rx_valid_o` is low.
- R3: `rx_enb_no` is a register. It is high in the cycle after any edge at which `rx_ready_i` was low.
- R4: In cell mode, at a cell boundary (byte count 0 after the edge), `rx_enb_no` goes low only if `rx_stat_i` was high at that edge. Inside a cell, `rx_stat_i` is ignored.
- R5: Each cell has 53 bytes, numbered 0 to 52. A byte captured at count 0 with `rx_soc_i` high is delivered with `rx_sop_o` high. Byte 52 is delivered with `rx_eoc_o` high. A byte captured at count 0 with `rx_soc_i` low is dropped, and `rx_valid_o` stays low.
- R6: If `rx_soc_i` is high on a byte captured at a nonzero count, `rx_frm_err_o` pulses together with `rx_sop_o`. That byte becomes byte 0 of a new cell. The downstream buffer discards the truncated cell.
- R7: A transmit byte is taken at an edge where both `tx_valid_i` and `tx_ready_o` are high. In the following cycle it is on `tx_data_o` with `tx_enb_no` low. `tx_soc_o` is high exactly on byte 0.
- R8: A transmit byte offered at count 0 with `tx_sop_i` low is consumed and dropped. `tx_enb_no` stays high.
- R9: In octet mode, `tx_ready_o` is low while `tx_stat_i` is low, so no byte is launched.
- R10: In cell mode, a cell may start only if `tx_stat_i` is high at count 0. After the first byte, `tx_stat_i` is ignored for the rest of the cell.
- R11: While `tx_active_i` is low, `tx_ready_o` is low and `tx_enb_no` is high in the next cycle. This includes the time after reset.
- R12: On transmit, `tx_soc_o` is asserted once for every 53 bytes launched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock for both paths, forwarded to the PHY |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cell_mode_i | input | 1 | 0 octet handshake, 1 cell handshake (static) |
| rx_data_i | input | 8 | Receive byte from PHY |
| rx_soc_i | input | 1 | Receive start of cell from PHY |
| rx_stat_i | input | 1 | Octet mode: byte valid (not empty); cell mode: cell available |
| rx_enb_no | output | 1 | Receive enable to PHY, active low |
| rx_ready_i | input | 1 | Internal receive buffer can accept |
| rx_byte_o | output | 8 | Delivered receive byte |
| rx_valid_o | output | 1 | Delivered byte valid |
| rx_sop_o | output | 1 | Delivered byte is byte 0 |
| rx_eoc_o | output | 1 | Delivered byte is byte 52 |
| rx_frm_err_o | output | 1 | Misplaced start of cell seen |
| tx_active_i | input | 1 | A transmit channel is active |
| tx_byte_i | input | 8 | Internal transmit byte |
| tx_sop_i | input | 1 | Internal byte is byte 0 |
| tx_valid_i | input | 1 | Internal byte offered |
| tx_ready_o | output | 1 | Offered byte is taken this cycle |
| tx_data_o | output | 8 | Transmit byte to PHY |
| tx_soc_o | output | 1 | Transmit start of cell |
| tx_enb_no | output | 1 | Transmit byte valid, active low |
| tx_stat_i | input | 1 | Octet mode: room (not full); cell mode: cell available |

## Verification
A wrong byte counter on either path would show up on the first cell: a misplaced `rx_eoc_o`, `rx_sop_o` or `tx_soc_o`, or a spurious `rx_frm_err_o`, no later than byte 52. A wrong enable state shows at the port one cycle after the edge that caused it. Examples are an enable left asserted after `rx_ready_i` drops, a boundary in cell mode entered without cell-available, or a byte launched against a full flag. Dropped or duplicated bytes appear as data mismatches in the same cycle.

// File: rtl/utopia_pkg.sv
`timescale 1ns/1ps
package utopia_pkg;
  typedef enum logic {
    MODE_OCTET = 1'b0,
    MODE_CELL  = 1'b1
  } xfer_mode_e;

  localparam int unsigned CELL_LEN = 53;
  localparam int unsigned BYTE_W   = 8;
endpackage

// File: rtl/utopia_cell_cnt.sv
`timescale 1ns/1ps
module utopia_cell_cnt #(
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic restart_i,
  output logic first_o,
  output logic last_o,
  output logic next_first_o
);
  localparam int unsigned CNT_W = $clog2(CELL_BYTES);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(CELL_BYTES - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (step_i) begin
      if (restart_i)             cnt_d = CNT_W'(1);  // this byte was byte 0
      else if (cnt_q == LAST_IDX) cnt_d = '0;
      else                       cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign first_o      = (cnt_q == '0);
  assign last_o       = (cnt_q == LAST_IDX);
  assign next_first_o = (cnt_d == '0);
endmodule

// File: rtl/utopia_rx.sv
`timescale 1ns/1ps
module utopia_rx
  import utopia_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_mode_e        mode_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_soc_i,
  input  logic              rx_stat_i,
  output logic              rx_enb_no,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_sop_o,
  output logic              rx_eoc_o,
  output logic              rx_frm_err_o
);
  logic take, hunt_drop, bad_soc, step;
  logic first, last, next_first;

  assign take      = !rx_enb_no && ((mode_i == MODE_CELL) || rx_stat_i);
  assign hunt_drop = take && first && !rx_soc_i;
  assign bad_soc   = take && !first && rx_soc_i;
  assign step      = take && !hunt_drop;

  utopia_cell_cnt #(.CELL_BYTES(CELL_BYTES)) cnt_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .restart_i   (bad_soc),
    .first_o     (first),
    .last_o      (last),
    .next_first_o(next_first)
  );

  // cell mode: boundary needs cell-available, mid-cell runs free
  logic enb_d;
  assign enb_d = rx_ready_i && ((mode_i == MODE_OCTET) || !next_first || rx_stat_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_enb_no    <= 1'b1;
      rx_byte_o    <= '0;
      rx_valid_o   <= 1'b0;
      rx_sop_o     <= 1'b0;
      rx_eoc_o     <= 1'b0;
      rx_frm_err_o <= 1'b0;
    end else begin
      rx_enb_no    <= !enb_d;
      rx_valid_o   <= step;
      rx_sop_o     <= step && rx_soc_i;
      rx_eoc_o     <= step && last && !bad_soc;
      rx_frm_err_o <= bad_soc;
      if (step) rx_byte_o <= rx_data_i;
    end
  end
endmodule

// File: rtl/utopia_tx.sv
`timescale 1ns/1ps
module utopia_tx
  import utopia_pkg::*;
#(
  parameter int unsigned DATA_W     = 8,
  parameter int unsigned CELL_BYTES = 53
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  xfer_mode_e        mode_i,
  input  logic              tx_active_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_sop_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_soc_o,
  output logic              tx_enb_no,
  input  logic              tx_stat_i
);
  logic first, last, next_first;
  logic permit, take, drop, step;

  always_comb begin
    unique case (mode_i)
      MODE_CELL:  permit = !first || tx_stat_i;
      default:    permit = tx_stat_i;
    endcase
  end

  assign tx_ready_o = tx_active_i && permit;
  assign take       = tx_valid_i && tx_ready_o;
  assign drop       = take && first && !tx_sop_i;
  assign step       = take && !drop;

  utopia_cell_cnt #(.CELL_BYTES(CELL_BYTES)) cnt_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .step_i      (step),
    .restart_i   (1'b0),
    .first_o     (first),
    .last_o      (last),
    .next_first_o(next_first)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_enb_no <= 1'b1;
      tx_soc_o  <= 1'b0;
      tx_data_o <= '0;
    end else begin
      tx_enb_no <= !step;
      tx_soc_o  <= step && first;
      if (step) tx_data_o <= tx_byte_i;
    end
  end

  logic unused_cnt;
  assign unused_cnt = last ^ next_first;
endmodule

// File: rtl/utopia_port.sv
`timescale 1ns/1ps
module utopia_port
  import utopia_pkg::*;
#(
  parameter int unsigned DATA_W     = BYTE_W,
  parameter int unsigned CELL_BYTES = CELL_LEN
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cell_mode_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_soc_i,
  input  logic              rx_stat_i,
  output logic              rx_enb_no,
  input  logic              rx_ready_i,
  output logic [DATA_W-1:0] rx_byte_o,
  output logic              rx_valid_o,
  output logic              rx_sop_o,
  output logic              rx_eoc_o,
  output logic              rx_frm_err_o,
  input  logic              tx_active_i,
  input  logic [DATA_W-1:0] tx_byte_i,
  input  logic              tx_sop_i,
  input  logic              tx_valid_i,
  output logic              tx_ready_o,
  output logic [DATA_W-1:0] tx_data_o,
  output logic              tx_soc_o,
  output logic              tx_enb_no,
  input  logic              tx_stat_i
);
  xfer_mode_e mode;
  assign mode = xfer_mode_e'(cell_mode_i);

  utopia_rx #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) rx_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (mode),
    .rx_data_i   (rx_data_i),
    .rx_soc_i    (rx_soc_i),
    .rx_stat_i   (rx_stat_i),
    .rx_enb_no   (rx_enb_no),
    .rx_ready_i  (rx_ready_i),
    .rx_byte_o   (rx_byte_o),
    .rx_valid_o  (rx_valid_o),
    .rx_sop_o    (rx_sop_o),
    .rx_eoc_o    (rx_eoc_o),
    .rx_frm_err_o(rx_frm_err_o)
  );

  utopia_tx #(.DATA_W(DATA_W), .CELL_BYTES(CELL_BYTES)) tx_i (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mode_i     (mode),
    .tx_active_i(tx_active_i),
    .tx_byte_i  (tx_byte_i),
    .tx_sop_i   (tx_sop_i),
    .tx_valid_i (tx_valid_i),
    .tx_ready_o (tx_ready_o),
    .tx_data_o  (tx_data_o),
    .tx_soc_o   (tx_soc_o),
    .tx_enb_no  (tx_enb_no),
    .tx_stat_i  (tx_stat_i)
  );
endmodule

// File: rtl/utopia_port_chk.sv
`timescale 1ns/1ps
module utopia_port_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic cell_mode_i,
  input logic rx_ready_i,
  input logic rx_enb_no,
  input logic rx_valid_o,
  input logic rx_sop_o,
  input logic rx_frm_err_o,
  input logic tx_active_i,
  input logic tx_stat_i,
  input logic tx_ready_o,
  input logic tx_enb_no,
  input logic tx_soc_o
);
  a_r3_rx_enb_follows_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rx_ready_i |=> rx_enb_no);

  a_r2_rx_valid_needs_enb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> $past(!rx_enb_no));

  a_r6_err_starts_cell: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_frm_err_o |-> (rx_sop_o && rx_valid_o));

  a_r7_soc_with_enb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_soc_o |-> !tx_enb_no);

  a_r9_full_blocks_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cell_mode_i && !tx_stat_i) |=> tx_enb_no);

  a_r11_idle_no_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_i |-> !tx_ready_o);

  a_r11_idle_no_enb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_active_i |=> tx_enb_no);
endmodule

bind utopia_port utopia_port_chk chk_i (.*);

// File: tb/utopia_port_tb_top.sv
`timescale 1ns/1ps
module utopia_port_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       cell_mode;
  logic [7:0] rx_data;
  logic       rx_soc, rx_stat, rx_enb_n, rx_ready;
  logic [7:0] rx_byte;
  logic       rx_valid, rx_sop, rx_eoc, rx_err;
  logic       tx_active;
  logic [7:0] tx_byte;
  logic       tx_sop, tx_valid, tx_ready;
  logic [7:0] tx_data;
  logic       tx_soc, tx_enb_n, tx_stat;

  int  total = 0;
  int  bad   = 0;
  bit  done  = 0;
  logic rdy_seen;

  always #5 clk = ~clk;

  utopia_port dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cell_mode_i(cell_mode),
    .rx_data_i(rx_data), .rx_soc_i(rx_soc), .rx_stat_i(rx_stat), .rx_enb_no(rx_enb_n),
    .rx_ready_i(rx_ready), .rx_byte_o(rx_byte), .rx_valid_o(rx_valid), .rx_sop_o(rx_sop),
    .rx_eoc_o(rx_eoc), .rx_frm_err_o(rx_err),
    .tx_active_i(tx_active), .tx_byte_i(tx_byte), .tx_sop_i(tx_sop), .tx_valid_i(tx_valid),
    .tx_ready_o(tx_ready), .tx_data_o(tx_data), .tx_soc_o(tx_soc), .tx_enb_no(tx_enb_n),
    .tx_stat_i(tx_stat)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // drive after a falling edge, return at the next falling edge
  task automatic rx_cyc(input logic [7:0] d, input logic soc, input logic stat);
    rx_data = d; rx_soc = soc; rx_stat = stat;
    @(negedge clk);
  endtask

  task automatic tx_cyc(input logic [7:0] d, input logic sop, input logic vld, input logic stat);
    tx_byte = d; tx_sop = sop; tx_valid = vld; tx_stat = stat;
    #1 rdy_seen = tx_ready;
    @(negedge clk);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; cell_mode = 1'b0;
    rx_data = '0; rx_soc = 1'b0; rx_stat = 1'b0; rx_ready = 1'b1;
    tx_active = 1'b0; tx_byte = '0; tx_sop = 1'b0; tx_valid = 1'b0; tx_stat = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1", "rx_enb_no", rx_enb_n, 1);
    chk("R1", "tx_enb_no", tx_enb_n, 1);
    chk("R1", "rx_valid", rx_valid, 0);
    chk("R1", "rx_err", rx_err, 0);
    chk("R1", "tx_soc", tx_soc, 0);
    rst_n = 1'b1;
    tx_cyc(8'h00, 1'b1, 1'b1, 1'b1);  // inactive channel at power-up
    chk("R11", "powerup ready", rdy_seen, 0);
    chk("R11", "powerup tx_enb_no", tx_enb_n, 1);
  endtask

  task automatic t_rx_octet();
    rx_cyc(8'h00, 1'b0, 1'b0);
    chk("R2", "enable after ready", rx_enb_n, 0);
    chk("R2", "no byte while empty", rx_valid, 0);
    rx_cyc(8'h40, 1'b1, 1'b1);
    chk("R2", "valid", rx_valid, 1);
    chk("R2", "byte0", rx_byte, 8'h40);
    chk("R5", "sop", rx_sop, 1);
    rx_cyc(8'hEE, 1'b0, 1'b0);
    chk("R2", "empty gap", rx_valid, 0);
    for (int i = 1; i < 53; i++) begin
      rx_cyc(8'(8'h40 + i), 1'b0, 1'b1);
      chk("R2", "valid", rx_valid, 1);
      chk("R2", "byte", rx_byte, 8'(8'h40 + i));
      chk("R5", "sop mid", rx_sop, 0);
      chk("R5", "eoc", rx_eoc, (i == 52));
    end
    rx_cyc(8'h99, 1'b0, 1'b1);
    chk("R5", "hunt drop", rx_valid, 0);
  endtask

  task automatic t_rx_ready();
    rx_ready = 1'b0;
    rx_cyc(8'h00, 1'b0, 1'b0);
    chk("R3", "enb off", rx_enb_n, 1);
    rx_cyc(8'h11, 1'b1, 1'b1);
    chk("R3", "no capture", rx_valid, 0);
    rx_ready = 1'b1;
    rx_cyc(8'h00, 1'b0, 1'b0);
    chk("R3", "enb back", rx_enb_n, 0);
  endtask

  task automatic t_rx_misframe();
    rx_cyc(8'h20, 1'b1, 1'b1);
    chk("R6", "first sop", rx_sop, 1);
    for (int i = 1; i < 5; i++) rx_cyc(8'(8'h20 + i), 1'b0, 1'b1);
    chk("R6", "no err yet", rx_err, 0);
    rx_cyc(8'h30, 1'b1, 1'b1);
    chk("R6", "err pulse", rx_err, 1);
    chk("R6", "new sop", rx_sop, 1);
    chk("R6", "no eoc", rx_eoc, 0);
    for (int i = 1; i < 53; i++) begin
      rx_cyc(8'(8'h30 + i), 1'b0, 1'b1);
      if (i == 1)  chk("R6", "err one cycle", rx_err, 0);
      if (i == 52) chk("R6", "eoc after restart", rx_eoc, 1);
    end
  endtask

  task automatic t_rx_cell();
    cell_mode = 1'b1;
    rx_cyc(8'h00, 1'b0, 1'b0);
    chk("R4", "no clav no enb", rx_enb_n, 1);
    rx_cyc(8'h00, 1'b0, 1'b1);
    chk("R4", "clav enables", rx_enb_n, 0);
    rx_cyc(8'h50, 1'b1, 1'b0);
    chk("R4", "byte0 valid", rx_valid, 1);
    chk("R4", "enb mid cell", rx_enb_n, 0);
    for (int i = 1; i < 53; i++) begin
      rx_cyc(8'(8'h50 + i), 1'b0, 1'b0);
      chk("R4", "mid byte", rx_byte, 8'(8'h50 + i));
      chk("R4", "mid valid", rx_valid, 1);
    end
    chk("R5", "eoc cell mode", rx_eoc, 1);
    chk("R4", "enb off at end", rx_enb_n, 1);
    rx_cyc(8'h77, 1'b1, 1'b0);
    chk("R4", "no next cell", rx_valid, 0);
    cell_mode = 1'b0;
    rx_cyc(8'h00, 1'b0, 1'b0);
  endtask

  task automatic tx_rest(input logic [7:0] base);
    for (int i = 1; i < 53; i++) begin
      tx_cyc(8'(base + i), 1'b0, 1'b1, 1'b1);
      chk("R7", "tx byte", tx_data, 8'(base + i));
      chk("R7", "tx enb", tx_enb_n, 0);
      chk("R12", "soc mid", tx_soc, 0);
    end
  endtask

  task automatic t_tx_octet();
    tx_active = 1'b1;
    tx_cyc(8'hA0, 1'b1, 1'b1, 1'b1);
    chk("R7", "ready", rdy_seen, 1);
    chk("R7", "enb", tx_enb_n, 0);
    chk("R7", "data", tx_data, 8'hA0);
    chk("R7", "soc", tx_soc, 1);
    tx_rest(8'hA0);
    tx_cyc(8'hB0, 1'b1, 1'b1, 1'b1);
    chk("R12", "soc after 53", tx_soc, 1);
    tx_rest(8'hB0);
    tx_cyc(8'h00, 1'b0, 1'b0, 1'b1);
    chk("R7", "idle enb", tx_enb_n, 1);
  endtask

  task automatic t_tx_full();
    tx_cyc(8'hC0, 1'b1, 1'b1, 1'b0);
    chk("R9", "ready while full", rdy_seen, 0);
    chk("R9", "enb while full", tx_enb_n, 1);
    tx_cyc(8'hC0, 1'b1, 1'b1, 1'b1);
    chk("R9", "sent after room", tx_soc, 1);
    tx_cyc(8'hC1, 1'b0, 1'b1, 1'b0);
    chk("R9", "mid full ready", rdy_seen, 0);
    chk("R9", "mid full enb", tx_enb_n, 1);
    tx_rest(8'hC0);
  endtask

  task automatic t_tx_drop();
    tx_cyc(8'hD0, 1'b0, 1'b1, 1'b1);
    chk("R8", "consumed", rdy_seen, 1);
    chk("R8", "not sent", tx_enb_n, 1);
    tx_cyc(8'hD1, 1'b1, 1'b1, 1'b1);
    chk("R8", "next sent", tx_enb_n, 0);
    chk("R8", "next data", tx_data, 8'hD1);
    chk("R8", "next soc", tx_soc, 1);
    tx_rest(8'hD1);
  endtask

  task automatic t_tx_cell();
    cell_mode = 1'b1;
    tx_cyc(8'hE0, 1'b1, 1'b1, 1'b0);
    chk("R10", "no clav ready", rdy_seen, 0);
    chk("R10", "no clav enb", tx_enb_n, 1);
    tx_cyc(8'hE0, 1'b1, 1'b1, 1'b1);
    chk("R10", "start soc", tx_soc, 1);
    for (int i = 1; i < 53; i++) begin
      tx_cyc(8'(8'hE0 + i), 1'b0, 1'b1, 1'b0);
      chk("R10", "mid ready", rdy_seen, 1);
      chk("R10", "mid data", tx_data, 8'(8'hE0 + i));
    end
    tx_cyc(8'hF5, 1'b1, 1'b1, 1'b0);
    chk("R10", "boundary blocks", rdy_seen, 0);
    chk("R10", "boundary enb", tx_enb_n, 1);
    cell_mode = 1'b0;
  endtask

  task automatic t_tx_inactive();
    tx_active = 1'b0;
    tx_cyc(8'hF0, 1'b1, 1'b1, 1'b1);
    chk("R11", "inactive ready", rdy_seen, 0);
    chk("R11", "inactive enb", tx_enb_n, 1);
    tx_active = 1'b1;
    tx_cyc(8'hF0, 1'b1, 1'b1, 1'b1);
    chk("R11", "active again", tx_enb_n, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    t_reset();
    t_rx_octet();
    t_rx_ready();
    t_rx_misframe();
    t_rx_cell();
    t_tx_octet();
    t_tx_full();
    t_tx_drop();
    t_tx_cell();
    t_tx_inactive();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule